// File: doc/BRIEF.md
# Phase-dimmer output current regulator

This block is the digital loop that balances input and output power in a two-stage LED driver when a phase-cut dimmer feeds an electronic transformer. The front stage runs with fixed settings, so the loop moves the LED current set-point instead. On each update it reads one sample of the intermediate (boost) voltage and the state of the overvoltage clamp. It then moves the LED current command so that the intermediate voltage returns to its hold band.

The voltage is an 8-bit code in which 256 stands for full scale. There are four programmable thresholds: an accelerated-decrease level, the lower and upper edges of the hold band, and the clamp flag. Together they split the input range into bands. Outside the band, the step size doubles on each consecutive update in the same direction, up to a cap. The clamp and the deep-low band both apply four times the current step.

When the command is already at its ceiling and the voltage is still too high, the block trims a boost-current scale factor instead of raising the command. When the voltage later drops, the block first restores that scale factor to nominal, and only then lowers the command.

Top module: `dim_current_loop`

## Requirements
- R1: On an update with `clamp_on`=0 and TH_LOW (default code 169) <= `vbst_code` <= TH_HIGH (default code 210), `led_cmd` and `boost_scale` keep their values.
- R2: On an update with `clamp_on`=0 and `vbst_code` > TH_HIGH, `led_cmd` rises by the effective step. The step is STEP_MIN (default 1) on the first such update and doubles on each further consecutive update in the same direction.
- R3: On an update with `clamp_on`=0 and TH_DEC < `vbst_code` < TH_LOW, `led_cmd` falls by the effective step. The step grows in the same way as in R2.
- R4: On an update with `clamp_on`=0 and `vbst_code` <= TH_DEC (default code 155), `led_cmd` falls by four times the effective step. This band and the R3 band count as one direction, so the step sequence carries across them.
- R5: On an update with `clamp_on`=1, the update counts as upward whatever `vbst_code` is, and `led_cmd` rises by four times the effective step.
- R6: On an upward update while `led_cmd` equals CMD_MAX (default 1023), `led_cmd` stays put and `boost_scale` drops by SCALE_STEP (default 8). `boost_scale` never goes below SCALE_MIN (default 64).
- R7: On a downward update while `boost_scale` is below SCALE_NOM (default 255), `boost_scale` rises by SCALE_STEP, capped at SCALE_NOM, and `led_cmd` stays put.
- R8: `led_cmd` saturates at CMD_MAX and at CMD_MIN (default 51, 5% of full scale) and never wraps.
- R9: The effective step is capped at STEP_MAX (default 32). It returns to STEP_MIN after a hold-band update or a change of direction.
- R10: After reset, `led_cmd` is CMD_INIT (default 512) and `boost_scale` is SCALE_NOM. Both change only in the clock cycle after a cycle with `sample_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new voltage sample |
| vbst_code | input | 8 | Intermediate voltage, 256 = full scale |
| clamp_on | input | 1 | Overvoltage clamp currently active |
| led_cmd | output | CMD_W (10) | LED current command word |
| boost_scale | output | SCALE_W (8) | Boost-current scale factor, SCALE_NOM = nominal |

## Verification
The embedded assertions check five properties on every clock cycle:
- Idle cycles and hold-band updates leave both outputs unchanged.
- Updates above the band never lower the command.
- The command stays between its floor and its ceiling.
- The scale factor sits below nominal only while the command is at its ceiling.
- The command is frozen while the scale factor is being restored.

Some behaviour can only be shown by the bench's scenarios. This covers the exact sizes of the doubling steps, the times-four multiplier in the clamp and deep-low bands, the step cap, and the reset of the step on band re-entry or a change of direction. It also covers the order of the handoff (trim, then restore, then lower) and the exact boundary codes 155, 169 and 210.

// File: rtl/dim_current_loop.sv
module dim_current_loop #(
  parameter int            CMD_W      = 10,
  parameter int            SCALE_W    = 8,
  parameter int            STEP_MAX   = 32,
  parameter logic [7:0]    TH_DEC     = 8'd155,
  parameter logic [7:0]    TH_LOW     = 8'd169,
  parameter logic [7:0]    TH_HIGH    = 8'd210,
  parameter logic [CMD_W-1:0]   CMD_MIN  = 10'd51,
  parameter logic [CMD_W-1:0]   CMD_MAX  = 10'd1023,
  parameter logic [CMD_W-1:0]   CMD_INIT = 10'd512,
  parameter logic [SCALE_W-1:0] SCALE_NOM  = 8'd255,
  parameter logic [SCALE_W-1:0] SCALE_MIN  = 8'd64,
  parameter logic [SCALE_W-1:0] SCALE_STEP = 8'd8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_valid,
  input  logic [7:0]         vbst_code,
  input  logic               clamp_on,
  output logic [CMD_W-1:0]   led_cmd,
  output logic [SCALE_W-1:0] boost_scale
);
  localparam int STEP_W = $clog2(STEP_MAX + 1);
  localparam int AMT_W  = STEP_W + 2;
  localparam int WIDE   = CMD_W + AMT_W + 1;
  localparam int SW     = SCALE_W + 1;
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_CAP = STEP_W'(STEP_MAX);

  typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_UP = 2'd1, DIR_DN = 2'd2} dir_t;

  dir_t              dir_q, dir_now;
  logic [STEP_W-1:0] step_q, eff, step_nxt;
  logic [STEP_W:0]   dbl;
  logic [AMT_W-1:0]  amount;
  logic              fast;
  logic [WIDE-1:0]   cmd_w, amt_w, up_sum;
  logic [CMD_W-1:0]  cmd_up, cmd_dn;
  logic [SW-1:0]     sc_w;
  logic [SCALE_W-1:0] sc_up, sc_dn;

  assign dir_now = clamp_on ? DIR_UP :
                   (vbst_code > TH_HIGH) ? DIR_UP :
                   (vbst_code < TH_LOW)  ? DIR_DN : DIR_NONE;
  assign fast = clamp_on || (dir_now == DIR_DN && vbst_code <= TH_DEC);
  assign eff  = (dir_now == dir_q) ? step_q : STEP_ONE;
  assign dbl  = {eff, 1'b0};
  assign step_nxt = (dbl > {1'b0, STEP_CAP}) ? STEP_CAP : dbl[STEP_W-1:0];
  assign amount = fast ? {eff, 2'b00} : {2'b00, eff};

  assign cmd_w  = WIDE'(led_cmd);
  assign amt_w  = WIDE'(amount);
  assign up_sum = cmd_w + amt_w;
  assign cmd_up = (up_sum > WIDE'(CMD_MAX)) ? CMD_MAX : up_sum[CMD_W-1:0];
  assign cmd_dn = (cmd_w < WIDE'(CMD_MIN) + amt_w) ? CMD_MIN : led_cmd - CMD_W'(amount);

  assign sc_w  = SW'(boost_scale);
  assign sc_dn = (sc_w < SW'(SCALE_MIN) + SW'(SCALE_STEP)) ? SCALE_MIN : boost_scale - SCALE_STEP;
  assign sc_up = (sc_w + SW'(SCALE_STEP) > SW'(SCALE_NOM)) ? SCALE_NOM : boost_scale + SCALE_STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_cmd     <= CMD_INIT;
      boost_scale <= SCALE_NOM;
      step_q      <= STEP_ONE;
      dir_q       <= DIR_NONE;
    end else if (sample_valid) begin
      dir_q  <= dir_now;
      step_q <= (dir_now == DIR_NONE) ? STEP_ONE : step_nxt;
      case (dir_now)
        DIR_UP: begin
          if (led_cmd == CMD_MAX) boost_scale <= sc_dn;
          else                    led_cmd     <= cmd_up;
        end
        DIR_DN: begin
          if (boost_scale < SCALE_NOM) boost_scale <= sc_up;
          else                         led_cmd     <= cmd_dn;
        end
        default: ;
      endcase
    end
  end

  a_r1_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !clamp_on && vbst_code >= TH_LOW && vbst_code <= TH_HIGH
    |=> $stable(led_cmd) && $stable(boost_scale));

  a_r2_up_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && (clamp_on || vbst_code > TH_HIGH) |=> led_cmd >= $past(led_cmd));

  a_r6_trim_only_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    boost_scale < SCALE_NOM |-> led_cmd == CMD_MAX);

  a_r7_restore_first: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !clamp_on && vbst_code < TH_LOW && boost_scale < SCALE_NOM
    |=> $stable(led_cmd));

  a_r8_cmd_range: assert property (@(posedge clk) disable iff (!rst_n)
    led_cmd >= CMD_MIN && led_cmd <= CMD_MAX);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(led_cmd) && $stable(boost_scale));
endmodule

// File: tb/dim_current_loop_test.sv
module dim_current_loop_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_valid = 1'b0;
  logic [7:0] vbst_code = 8'd190;
  logic clamp_on = 1'b0;
  logic [9:0] led_cmd;
  logic [7:0] boost_scale;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dim_current_loop uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .vbst_code(vbst_code), .clamp_on(clamp_on),
    .led_cmd(led_cmd), .boost_scale(boost_scale)
  );

  localparam int NV = 31;
  localparam logic [26:0] VEC [NV] = '{
    {8'd190, 1'b0, 10'd512,  8'd255},
    {8'd220, 1'b0, 10'd513,  8'd255},
    {8'd220, 1'b0, 10'd515,  8'd255},
    {8'd220, 1'b0, 10'd519,  8'd255},
    {8'd190, 1'b0, 10'd519,  8'd255},
    {8'd220, 1'b0, 10'd520,  8'd255},
    {8'd160, 1'b0, 10'd519,  8'd255},
    {8'd160, 1'b0, 10'd517,  8'd255},
    {8'd150, 1'b0, 10'd501,  8'd255},
    {8'd150, 1'b0, 10'd469,  8'd255},
    {8'd200, 1'b0, 10'd469,  8'd255},
    {8'd200, 1'b1, 10'd473,  8'd255},
    {8'd200, 1'b1, 10'd481,  8'd255},
    {8'd200, 1'b1, 10'd497,  8'd255},
    {8'd200, 1'b1, 10'd529,  8'd255},
    {8'd200, 1'b1, 10'd593,  8'd255},
    {8'd200, 1'b1, 10'd721,  8'd255},
    {8'd200, 1'b1, 10'd849,  8'd255},
    {8'd200, 1'b1, 10'd977,  8'd255},
    {8'd200, 1'b1, 10'd1023, 8'd255},
    {8'd220, 1'b0, 10'd1023, 8'd247},
    {8'd220, 1'b0, 10'd1023, 8'd239},
    {8'd220, 1'b0, 10'd1023, 8'd231},
    {8'd160, 1'b0, 10'd1023, 8'd239},
    {8'd160, 1'b0, 10'd1023, 8'd247},
    {8'd160, 1'b0, 10'd1023, 8'd255},
    {8'd160, 1'b0, 10'd1015, 8'd255},
    {8'd169, 1'b0, 10'd1015, 8'd255},
    {8'd210, 1'b0, 10'd1015, 8'd255},
    {8'd155, 1'b0, 10'd1011, 8'd255},
    {8'd156, 1'b0, 10'd1009, 8'd255}
  };

  function automatic string vec_req(int i);
    if (i == 0 || i == 4 || i == 10) return "R1 hold";
    if (i <= 3 || i == 5) return "R2 up";
    if (i <= 7) return "R3 down";
    if (i <= 9) return "R4 fast down";
    if (i <= 16) return "R5 clamp";
    if (i <= 19) return "R9 step cap / R8 ceiling";
    if (i <= 22) return "R6 trim";
    if (i <= 26) return "R7 restore";
    if (i <= 28) return "R1 band edges";
    return "R4 dec edge";
  endfunction

  task automatic check(string req, logic [9:0] ec, logic [7:0] es);
    checks++;
    if (led_cmd !== ec || boost_scale !== es) begin
      failures++;
      $display("FAIL %s: cmd=%0d scale=%0d expected cmd=%0d scale=%0d",
               req, led_cmd, boost_scale, ec, es);
    end
  endtask

  task automatic update(logic [7:0] v, logic c);
    @(negedge clk);
    vbst_code = v; clamp_on = c; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset", 10'd512, 8'd255);

    vbst_code = 8'd240; clamp_on = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle without strobe", 10'd512, 8'd255);

    for (int i = 0; i < NV; i++) begin
      update(VEC[i][26:19], VEC[i][18]);
      check(vec_req(i), VEC[i][17:8], VEC[i][7:0]);
    end

    for (int k = 0; k < 12; k++) update(8'd100, 1'b0);
    check("R8 floor", 10'd51, 8'd255);
    update(8'd100, 1'b0);
    check("R8 floor no wrap", 10'd51, 8'd255);

    update(8'd190, 1'b0);
    update(8'd120, 1'b1);
    check("R5 clamp beats low band", 10'd55, 8'd255);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset again", 10'd512, 8'd255);
    update(8'd220, 1'b0);
    check("R9 step restart after reset", 10'd513, 8'd255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule